// File: doc/BRIEF.md
# Maskable Interrupt Status and Request Unit

This block gathers seven interrupt conditions of a serial port into one status register, gates them with a software-written mask and drives a single active-low request line to the host. The receiver, transmitter and counter are not part of the block. They appear only as one-cycle set pulses. Two asynchronous lines, a break indicator and a general-purpose input, are synchronized inside the block. Each of their transitions latches a change flag.

A condition does not clear when the host writes its status bit. Each one stays set until the bus event that services it. A read of the receive holding register, a write of the transmit holding register or a specific command code each clears its own group of bits. Reading the status register also returns the current synchronized level of the general-purpose input.

Top module: `irq_ctrl`

## Requirements
- R1: While rst_ni is low, status_o reads 8'h00 and irq_no is 1. The mask register is also cleared.
- R2: A one-cycle high on tx_ready_i, tx_empty_i, rx_ready_i, rx_full_i or ctr_ready_i sets status bit 0, 1, 2, 3 or 5 respectively at the next clock edge. The bit stays set until its clear event.
- R3: irq_no is low exactly when, at the previous clock edge, the AND of status bits 6..0 and the mask had a bit set. Otherwise irq_no is high.
- R4: A one-cycle rhr_rd_i clears status bits 2 and 3.
- R5: A one-cycle thr_wr_i clears status bits 0 and 1.
- R6: When cmd_we_i is high, cmd_i = 4'h5 clears bit 4, 4'hA clears bit 6 and 4'hC clears bit 5. Any other code changes no status bit.
- R7: Any transition of brk_i sets bit 4 on the third clock edge after the change, and any transition of gpin_i sets bit 6 on the third clock edge after the change.
- R8: Status bit 7 shows gpin_i delayed by two clock edges. It is not maskable and no event clears it.
- R9: When a set event and a clear event reach the same status bit in the same cycle, the bit ends up set.
- R10: mask_we_i loads mask_i[6:0] as the enable for status bits 6..0. When a mask write removes the only enabled pending bit, irq_no returns high one edge after the mask register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_ready_i | input | 1 | Set pulse for the transmit-ready condition |
| tx_empty_i | input | 1 | Set pulse for the transmit-empty condition |
| rx_ready_i | input | 1 | Set pulse for the receive-ready condition |
| rx_full_i | input | 1 | Set pulse for the receive-full condition |
| ctr_ready_i | input | 1 | Set pulse for the counter-ready condition |
| brk_i | input | 1 | Asynchronous break level |
| gpin_i | input | 1 | Asynchronous general-purpose input |
| rhr_rd_i | input | 1 | Receive holding register read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_i | input | 4 | Command code |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_i | input | 7 | New mask value |
| status_o | output | 8 | Status register: bits 6..0 are conditions, bit 7 is the input level |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
A status bit held in the wrong state shows on status_o at the first sample after the offending edge. It also shows on irq_no one edge later once its mask bit is set, so a lost clear or a lost set is visible within two cycles. A wrong synchronizer depth moves bits 4, 6 and 7 by a whole cycle against the three- and two-edge latencies. Same-cycle set and clear collisions are driven on purpose, because a wrong priority leaves a bit clear that must read set.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC    = 7;
  localparam int CMD_W   = 4;
  localparam int SYNC_N  = 2;

  localparam int B_TXRDY = 0;
  localparam int B_TXEMT = 1;
  localparam int B_RXRDY = 2;
  localparam int B_RXFUL = 3;
  localparam int B_BRK   = 4;
  localparam int B_CTR   = 5;
  localparam int B_GPIN  = 6;

  localparam logic [CMD_W-1:0] CMD_CLR_BRK  = 4'h5;
  localparam logic [CMD_W-1:0] CMD_CLR_GPIN = 4'hA;
  localparam logic [CMD_W-1:0] CMD_STOP_CTR = 4'hC;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] sync_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= '0;
    else         sync_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s] <= '0;
      else         sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign level_o = sync_q[STAGES-1];
  assign edge_o  = sync_q[STAGES-1] ^ prev_q;

  // edge seen now means the level differs from the one registered a cycle earlier
  assert_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (edge_o == (level_o ^ $past(level_o))));
endmodule

// File: rtl/irq_status_bits.sv
module irq_status_bits #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;  // set has priority
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end

    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q_o[i]);
    assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !q_o[i]);
    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[i] && !set_i[i]) |=> $stable(q_o[i]));
  end
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_no <= 1'b1;
    else         irq_no <= ~|(stat_i & mask_i);
  end

  assert_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_no == !$past(|(stat_i & mask_i))));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_ready_i,
  input  logic             tx_empty_i,
  input  logic             rx_ready_i,
  input  logic             rx_full_i,
  input  logic             ctr_ready_i,
  input  logic             brk_i,
  input  logic             gpin_i,
  input  logic             rhr_rd_i,
  input  logic             thr_wr_i,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             mask_we_i,
  input  logic [NSRC-1:0]  mask_i,
  output logic [NSRC:0]    status_o,
  output logic             irq_no
);
  logic [1:0]      lvl, edg;
  logic [NSRC-1:0] set_v, clr_v, stat_q, mask_q;

  irq_sync_edge #(.W(2), .STAGES(SYNC_N)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({gpin_i, brk_i}),
    .level_o (lvl),
    .edge_o  (edg)
  );

  always_comb begin
    set_v          = '0;
    set_v[B_TXRDY] = tx_ready_i;
    set_v[B_TXEMT] = tx_empty_i;
    set_v[B_RXRDY] = rx_ready_i;
    set_v[B_RXFUL] = rx_full_i;
    set_v[B_BRK]   = edg[0];
    set_v[B_CTR]   = ctr_ready_i;
    set_v[B_GPIN]  = edg[1];

    clr_v          = '0;
    clr_v[B_TXRDY] = thr_wr_i;
    clr_v[B_TXEMT] = thr_wr_i;
    clr_v[B_RXRDY] = rhr_rd_i;
    clr_v[B_RXFUL] = rhr_rd_i;
    clr_v[B_BRK]   = cmd_we_i && (cmd_i == CMD_CLR_BRK);
    clr_v[B_CTR]   = cmd_we_i && (cmd_i == CMD_STOP_CTR);
    clr_v[B_GPIN]  = cmd_we_i && (cmd_i == CMD_CLR_GPIN);
  end

  irq_status_bits #(.W(NSRC)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .q_o    (stat_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_i;
  end

  irq_req_gen #(.W(NSRC)) u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stat_i (stat_q),
    .mask_i (mask_q),
    .irq_no (irq_no)
  );

  assign status_o = {lvl[1], stat_q};

  assert_mask_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_q == $past(mask_i)));
  assert_mask_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q));
  assert_thr_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_wr_i && !tx_ready_i) |=> !status_o[B_TXRDY]);
  assert_rhr_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rhr_rd_i && !rx_ready_i) |=> !status_o[B_RXRDY]);
endmodule

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic txr = 0, txe = 0, rxr = 0, rxf = 0, ctr = 0, brk = 0, gpin = 0;
  logic rhr = 0, thr = 0, cwe = 0, mwe = 0;
  logic [3:0] cmd = 0;
  logic [6:0] mask = 0;
  logic [7:0] stat;
  logic       irq_n;
  int tests = 0, fails = 0;
  logic auto_chk = 1'b0;

  always #5 clk = ~clk;

  irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .tx_ready_i(txr), .tx_empty_i(txe),
    .rx_ready_i(rxr), .rx_full_i(rxf), .ctr_ready_i(ctr), .brk_i(brk),
    .gpin_i(gpin), .rhr_rd_i(rhr), .thr_wr_i(thr), .cmd_we_i(cwe),
    .cmd_i(cmd), .mask_we_i(mwe), .mask_i(mask), .status_o(stat), .irq_no(irq_n)
  );

  // reference model built from the requirements
  logic       b1, b2, bp, g1, g2, gp;
  logic [6:0] m_stat, m_mask;
  logic       m_irq_n;

  function automatic logic [6:0] set_vec(logic [6:0] cur_edges);
    return {cur_edges[1], ctr, cur_edges[0], rxf, rxr, txe, txr};
  endfunction

  function automatic logic [6:0] clr_vec();
    logic [6:0] c = '0;
    c[0] = thr; c[1] = thr; c[2] = rhr; c[3] = rhr;
    c[4] = cwe && cmd == 4'h5;
    c[5] = cwe && cmd == 4'hC;
    c[6] = cwe && cmd == 4'hA;
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {b1, b2, bp, g1, g2, gp} <= '0;
      m_stat <= '0; m_mask <= '0; m_irq_n <= 1'b1;
    end else begin
      b1 <= brk; b2 <= b1; bp <= b2;
      g1 <= gpin; g2 <= g1; gp <= g2;
      m_stat  <= (m_stat & ~clr_vec()) | set_vec({g2 ^ gp, b2 ^ bp});
      m_irq_n <= !(|(m_stat & m_mask));
      if (mwe) m_mask <= mask;
    end
  end

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (auto_chk) begin
    check("R2", stat, {g2, m_stat});
    check("R3", {7'd0, irq_n}, {7'd0, m_irq_n});
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    {txr, txe, rxr, rxf, ctr, rhr, thr, cwe, mwe} = '0;
    cmd = 4'h0;
  endtask

  initial begin : watchdog
    #1ms;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h2691_0001);
    tick(2);
    check("R1", stat, 8'h00);
    check("R1", {7'd0, irq_n}, 8'h01);
    rst_n = 1'b1;
    tick();
    auto_chk = 1'b1;

    // R2: set pulses, mask still zero
    {txr, txe, rxr, rxf, ctr} = '1; tick(); idle();
    check("R2", stat, 8'h2F);
    tick();
    check("R3", {7'd0, irq_n}, 8'h01);

    // R10/R3: enable bit 0
    mask = 7'h01; mwe = 1; tick(); idle();
    check("R3", {7'd0, irq_n}, 8'h01);
    tick();
    check("R3", {7'd0, irq_n}, 8'h00);

    thr = 1; tick(); idle();
    check("R5", stat, 8'h2C);
    tick();
    check("R5", {7'd0, irq_n}, 8'h01);

    rhr = 1; tick(); idle();
    check("R4", stat, 8'h20);

    cwe = 1; cmd = 4'h3; tick(); idle();
    check("R6", stat, 8'h20);
    cwe = 1; cmd = 4'hC; tick(); idle();
    check("R6", stat, 8'h00);

    // R7/R8: synchronized edges and level
    brk = 1; gpin = 1; tick();
    check("R7", stat, 8'h00);
    tick();
    check("R8", stat, 8'h80);
    tick();
    check("R7", stat, 8'hD0);

    cwe = 1; cmd = 4'h5; tick(); idle();
    check("R6", stat, 8'hC0);
    cwe = 1; cmd = 4'hA; tick(); idle();
    check("R6", stat, 8'h80);

    // R9: set and clear in the same cycle
    ctr = 1; cwe = 1; cmd = 4'hC; txr = 1; thr = 1; tick(); idle();
    check("R9", stat, 8'hA1);
    tick();
    check("R10", {7'd0, irq_n}, 8'h00);
    mask = 7'h00; mwe = 1; tick(); idle();
    check("R10", {7'd0, irq_n}, 8'h00);
    tick();
    check("R10", {7'd0, irq_n}, 8'h01);

    // falling edge of brk also flags a change
    brk = 0; tick(3);
    check("R7", stat[4], 8'h01);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      txr = ($urandom % 8) == 0;
      txe = ($urandom % 8) == 0;
      rxr = ($urandom % 8) == 0;
      rxf = ($urandom % 8) == 0;
      ctr = ($urandom % 8) == 0;
      rhr = ($urandom % 6) == 0;
      thr = ($urandom % 6) == 0;
      cwe = ($urandom % 5) == 0;
      case ($urandom % 4)
        0: cmd = 4'h5;
        1: cmd = 4'hA;
        2: cmd = 4'hC;
        default: cmd = 4'($urandom);
      endcase
      mwe  = ($urandom % 16) == 0;
      mask = 7'($urandom);
      if (($urandom % 20) == 0) brk  = ~brk;
      if (($urandom % 20) == 0) gpin = ~gpin;
      tick();
    end
    idle();
    tick(4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule